// File: doc/BRIEF.md
# Dual-Port GPIO Interrupt-on-Change Controller

This block is a 16-pin general-purpose I/O core. It is built as two identical 8-bit ports, A and B. Each pin can be set as an input or an output. Output pins drive a per-port output latch. Input pins pass through a two-flop synchronizer, and their values can be inverted bit by bit when the host reads them.

Each input bit can raise an interrupt when it changes. Each bit uses one of two comparison modes: against the value it had on the previous clock, or against a stored reference byte. When a port interrupt fires, the synchronized port value is frozen in a capture register. The interrupt then holds until the host reads that port's capture register or its pin-read register.

Each port has one interrupt output. A control bit ties the two outputs together so that both follow the OR of the two ports. A second control bit makes both outputs active-low.

The host reaches every register over a simple synchronous bus. Registers are written on `bus_we`. On `bus_re` the addressed byte is registered onto `bus_rdata` at the same clock edge.

Each port holds a two-state interrupt machine:

| State | Meaning |
|---|---|
| IRQ_IDLE | No interrupt pending. The previous-value reference follows the synchronized pins. |
| IRQ_PENDING | An interrupt is pending. The capture register and the reference are frozen. |

| Transition | Condition |
|---|---|
| DETECT (IRQ_IDLE to IRQ_PENDING) | Any enabled input bit differs from its reference in the current cycle. |
| CLEAR (IRQ_PENDING to IRQ_IDLE) | A host read of that port's capture or pin-read register. |

Top module: `gpio_ioc_ctrl`

Register map. Port A sits at base 0 and port B at base 8. The offset within a port is given first:

| Offset | Register | Access | Reset |
|---|---|---|---|
| 0 | direction (1 = input) | read/write | 0xFF |
| 1 | polarity invert | read/write | 0x00 |
| 2 | interrupt enable | read/write | 0x00 |
| 3 | reference value | read/write | 0x00 |
| 4 | compare mode (1 = reference, 0 = previous value) | read/write | 0x00 |
| 5 | pin read | read-only, read clears | — |
| 6 | output latch | read/write | 0x00 |
| 7 | capture | read-only, read clears | 0x00 |

The control register is at address 16:
- bit 0 is mirror.
- bit 1 is active-low.
- the other bits read as 0.

## Requirements
- R1: After reset, every direction register reads 0xFF. The polarity, enable, reference, mode, latch, capture and control registers all read 0x00. Both interrupt outputs are low, and `pin_oe` is all zero.
- R2: Every read/write register returns the last value written to it. The control register keeps only bits 1:0. Writes to the pin-read and capture offsets have no effect. Read data appears on `bus_rdata` at the clock edge that samples `bus_re`.
- R3: A direction bit of 0 sets the matching `pin_oe` bit to 1. `pin_out` always equals the port's output latch.
- R4: A pin-read returns two things. Input bits give the synchronized pin XOR the polarity bit. Output bits give the latch bit. A pin change becomes readable from the second clock edge after it is applied.
- R5: In previous-value mode, a change on an enabled input bit asserts that port's interrupt at the third rising edge after the pin changes, and not before.
- R6: In reference mode (mode bit 1), an enabled input bit raises an interrupt while its synchronized value differs from the reference bit. The interrupt re-raises after a clear for as long as the difference remains.
- R7: A bit whose enable bit is 0, or whose direction bit is 0, never raises an interrupt.
- R8: At detection, the capture register loads the synchronized port value. It then stays unchanged while the interrupt is pending, even if pins change.
- R9: A read of a port's capture or pin-read register clears that port's pending interrupt at the read edge. Reads of other registers leave it pending.
- R10: With control bit 0 set, both interrupt outputs equal the OR of the two port interrupts. With it clear, each output follows only its own port.
- R11: With control bit 1 set, both interrupt outputs are active-low and sit at 1 when idle.
- R12: When a previous-value interrupt is cleared, the pin may differ from its value at detection. In that case the interrupt re-asserts one edge after the clear and captures the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; clears interrupts on capture or pin-read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Pin input values; [7:0] port A, [15:8] port B |
| pin_out | output | 16 | Output latch values |
| pin_oe | output | 16 | Output enable per pin |
| irq_a | output | 1 | Port A interrupt (or mirrored OR) |
| irq_b | output | 1 | Port B interrupt (or mirrored OR) |

## Verification
A host clearing read can land in the same cycle as a fresh change on an enabled pin. This is the CLEAR transition racing a new DETECT. The bench provokes it in two steps. First it moves the pin back while the interrupt is pending. Then it reads the capture register. The judgement is that the interrupt drops for exactly one cycle, re-asserts on the next edge, and returns the new pin value in the capture register. The reference-mode variant is checked the same way: a persistent mismatch must re-raise the interrupt right after every clear.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
    localparam int PORT_W = 8;
    localparam int OFF_W  = 3;

    typedef enum logic [OFF_W-1:0] {
        OFF_DIR   = 3'd0,
        OFF_POL   = 3'd1,
        OFF_IEN   = 3'd2,
        OFF_REF   = 3'd3,
        OFF_MODE  = 3'd4,
        OFF_PINS  = 3'd5,
        OFF_LATCH = 3'd6,
        OFF_CAP   = 3'd7
    } reg_off_e;

    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;
endpackage

// File: rtl/gpio_ioc_sync.sv
module gpio_ioc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_in;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port
    import gpio_ioc_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic         wr_en,
    input  logic [OFF_W-1:0] off,
    input  logic [W-1:0] wdata,
    input  logic         rd_clr,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic         pend
);
    logic [W-1:0] sin;
    logic [W-1:0] dir_q, pol_q, ien_q, ref_q, mode_q, latch_q, prev_q, cap_q;
    logic [W-1:0] hit_vec;
    logic         cap_load;
    irq_state_e   state_q, state_d;

    gpio_ioc_sync #(.W(W)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (pins),
        .d_sync (sin)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '1;
            pol_q   <= '0;
            ien_q   <= '0;
            ref_q   <= '0;
            mode_q  <= '0;
            latch_q <= '0;
        end else if (wr_en) begin
            unique case (reg_off_e'(off))
                OFF_DIR:   dir_q   <= wdata;
                OFF_POL:   pol_q   <= wdata;
                OFF_IEN:   ien_q   <= wdata;
                OFF_REF:   ref_q   <= wdata;
                OFF_MODE:  mode_q  <= wdata;
                OFF_LATCH: latch_q <= wdata;
                OFF_PINS, OFF_CAP: ;
            endcase
        end
    end

    // change detection and transitions
    always_comb begin
        hit_vec  = ien_q & dir_q &
                   ((mode_q & (sin ^ ref_q)) | (~mode_q & (sin ^ prev_q)));
        state_d  = state_q;
        cap_load = 1'b0;
        unique case (state_q)
            IRQ_IDLE: begin
                if (|hit_vec) begin
                    state_d  = IRQ_PENDING;
                    cap_load = 1'b1;
                end
            end
            IRQ_PENDING: begin
                if (rd_clr) state_d = IRQ_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    // reference and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            cap_q  <= '0;
        end else begin
            if (state_q == IRQ_IDLE) prev_q <= sin;
            if (cap_load)            cap_q  <= sin;
        end
    end

    // outputs
    always_comb begin
        pend    = (state_q == IRQ_PENDING);
        pin_out = latch_q;
        pin_oe  = ~dir_q;
        unique case (reg_off_e'(off))
            OFF_DIR:   rd_data = dir_q;
            OFF_POL:   rd_data = pol_q;
            OFF_IEN:   rd_data = ien_q;
            OFF_REF:   rd_data = ref_q;
            OFF_MODE:  rd_data = mode_q;
            OFF_PINS:  rd_data = (dir_q & (sin ^ pol_q)) | (~dir_q & latch_q);
            OFF_LATCH: rd_data = latch_q;
            OFF_CAP:   rd_data = cap_q;
        endcase
    end

    // R8
    cap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_PENDING) |=> $stable(cap_q));

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(|(ien_q & dir_q)));

    // R9
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_PENDING && rd_clr) |=> (state_q == IRQ_IDLE));

    // R12
    prev_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_IDLE) |=> (prev_q == $past(sin)));
endmodule

// File: rtl/gpio_ioc_ctrl.sv
module gpio_ioc_ctrl
    import gpio_ioc_pkg::*;
#(
    parameter int PW     = PORT_W,
    parameter int ADDR_W = OFF_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [PW-1:0]     bus_wdata,
    output logic [PW-1:0]     bus_rdata,
    input  logic [2*PW-1:0]   pin_in,
    output logic [2*PW-1:0]   pin_out,
    output logic [2*PW-1:0]   pin_oe,
    output logic              irq_a,
    output logic              irq_b
);
    localparam int NPORT = 2;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NPORT << OFF_W);

    logic [1:0]          ctrl_q;
    logic [NPORT-1:0]    sel;
    logic [NPORT-1:0]    pend;
    logic [PW-1:0]       prd [NPORT];
    logic [OFF_W-1:0]    off;
    logic                clr_off;
    logic                ctrl_sel;
    logic                raw_a, raw_b;
    logic [PW-1:0]       rd_mux;

    assign off      = bus_addr[OFF_W-1:0];
    assign clr_off  = (off == OFF_PINS) || (off == OFF_CAP);
    assign ctrl_sel = (bus_addr == CTRL_ADDR);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign sel[p] = (bus_addr[ADDR_W-1:OFF_W] == (ADDR_W-OFF_W)'(p));
        gpio_ioc_port #(.W(PW)) port_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .pins    (pin_in[p*PW +: PW]),
            .wr_en   (bus_we & sel[p]),
            .off     (off),
            .wdata   (bus_wdata),
            .rd_clr  (bus_re & sel[p] & clr_off),
            .rd_data (prd[p]),
            .pin_out (pin_out[p*PW +: PW]),
            .pin_oe  (pin_oe[p*PW +: PW]),
            .pend    (pend[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ctrl_q <= '0;
        else if (bus_we && ctrl_sel) ctrl_q <= bus_wdata[1:0];
    end

    always_comb begin
        if (ctrl_sel)    rd_mux = PW'(ctrl_q);
        else if (sel[0]) rd_mux = prd[0];
        else if (sel[1]) rd_mux = prd[1];
        else             rd_mux = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

    always_comb begin
        raw_a = ctrl_q[0] ? (pend[0] | pend[1]) : pend[0];
        raw_b = ctrl_q[0] ? (pend[0] | pend[1]) : pend[1];
        irq_a = raw_a ^ ctrl_q[1];
        irq_b = raw_b ^ ctrl_q[1];
    end

    // R10
    mirror_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[0] |-> (irq_a == irq_b));

    // R11
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (irq_a == ctrl_q[1] && irq_b == ctrl_q[1]));
endmodule

// File: tb/gpio_ioc_ctrl_tb.sv
module gpio_ioc_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  bus_addr;
    logic        bus_we, bus_re;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [15:0] pin_in, pin_out, pin_oe;
    logic        irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    logic [15:0] pins;
    logic [7:0]  shadow [17];
    logic [7:0]  rv;

    always #5 clk = ~clk;
    assign pin_in = pins;

    gpio_ioc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    function automatic logic [7:0] exp_port(logic [7:0] p, logic [7:0] dir,
                                            logic [7:0] pol, logic [7:0] lat);
        return (dir & (p ^ pol)) | (~dir & lat);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        if (a <= 16) shadow[a] = (a == 16) ? (d & 8'h03) : d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        for (int i = 0; i < 17; i++) shadow[i] = 8'h00;
        shadow[0] = 8'hFF; shadow[8] = 8'hFF;
        cycles(3);
    endtask

    task automatic clear_all();
        logic [7:0] d;
        rd(5'd7, d); rd(5'd15, d); rd(5'd7, d); rd(5'd15, d);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d, cap0;
        void'($urandom(32'd1234));
        bus_addr = '0; bus_we = 0; bus_re = 0; bus_wdata = '0;
        pins = 16'h0000;
        rst_n = 1'b0;
        do_reset();

        // R1 reset state
        for (int a = 0; a < 17; a++) begin
            if (a == 5 || a == 13) continue;
            rd(5'(a), d);
            check("R1 reset reg", {8'h0, d}, {8'h0, shadow[a]});
        end
        check("R1 irq outputs", {14'h0, irq_a, irq_b}, 16'h0);
        check("R1 pin_oe", pin_oe, 16'h0000);

        // R2 random readback
        for (int i = 0; i < 40; i++) begin
            int a;
            a = $urandom_range(0, 16);
            if (a == 5 || a == 7 || a == 13 || a == 15) a = 16;
            if (a == 0 || a == 8) continue;
            wr(5'(a), 8'($urandom));
        end
        for (int a = 0; a < 17; a++) begin
            if (a == 5 || a == 7 || a == 13 || a == 15) continue;
            rd(5'(a), d);
            check("R2 readback", {8'h0, d}, {8'h0, shadow[a]});
        end
        wr(5'd7, 8'h5A);
        rd(5'd7, d);
        check("R2 capture write ignored", {8'h0, d}, 16'h0000);

        // R3 direction and latch
        wr(5'd0, 8'h0F);
        wr(5'd6, 8'hA5);
        wr(5'd14, 8'h3C);
        cycles(1);
        check("R3 pin_oe", pin_oe, {~shadow[8], 8'hF0});
        check("R3 pin_out", pin_out, 16'h3CA5);

        // R4 random pin reads
        for (int i = 0; i < 12; i++) begin
            wr(5'd1, 8'($urandom));
            wr(5'd9, 8'($urandom));
            wr(5'd8, 8'($urandom));
            @(negedge clk);
            pins = 16'($urandom);
            cycles(2);
            rd(5'd5, d);
            check("R4 port A read", {8'h0, d},
                  {8'h0, exp_port(pins[7:0], shadow[0], shadow[1], shadow[6])});
            rd(5'd13, d);
            check("R4 port B read", {8'h0, d},
                  {8'h0, exp_port(pins[15:8], shadow[8], shadow[9], shadow[14])});
        end
        wr(5'd5, 8'hFF);
        rd(5'd5, d);
        check("R2 pin-read write ignored", {8'h0, d},
              {8'h0, exp_port(pins[7:0], shadow[0], shadow[1], shadow[6])});

        // interrupt tests from a clean state
        pins = 16'h0000;
        do_reset();
        wr(5'd2, 8'h03);
        cycles(3);

        // R5 timing
        pins[0] = 1'b1;
        cycles(2);
        check("R5 no early irq", {15'h0, irq_a}, 16'h0);
        cycles(1);
        check("R5 irq_a raised", {15'h0, irq_a}, 16'h1);
        check("R10 irq_b separate", {15'h0, irq_b}, 16'h0);

        // R9 non-clearing read
        rd(5'd0, d);
        check("R9 other read keeps irq", {15'h0, irq_a}, 16'h1);

        // R8 capture frozen
        pins[2] = 1'b1;
        cycles(4);
        rd(5'd7, d);
        check("R8 capture value", {8'h0, d}, 16'h0001);
        check("R9 capture read clears", {15'h0, irq_a}, 16'h0);
        cycles(2);
        check("R7 disabled bit no irq", {15'h0, irq_a}, 16'h0);

        // R7 output pin with enable set
        wr(5'd0, 8'hFD);
        cycles(2);
        pins[1] = 1'b1;
        cycles(5);
        check("R7 output pin no irq", {15'h0, irq_a}, 16'h0);
        wr(5'd0, 8'hFF);
        cycles(4);
        clear_all();

        // R12 change while pending, clear races new detect
        pins[0] = 1'b0;
        cycles(4);
        check("R12 first irq", {15'h0, irq_a}, 16'h1);
        pins[0] = 1'b1;
        cycles(4);
        rd(5'd7, cap0);
        check("R12 first capture", {8'h0, cap0}, 16'h0006);
        check("R12 dropped at clear", {15'h0, irq_a}, 16'h0);
        cycles(1);
        check("R12 re-raised", {15'h0, irq_a}, 16'h1);
        rd(5'd5, d);
        cycles(3);
        check("R12 stays clear", {15'h0, irq_a}, 16'h0);
        rd(5'd7, d);
        check("R12 new capture", {8'h0, d}, 16'h0007);

        // R6 reference mode
        wr(5'd3, 8'h01);
        wr(5'd4, 8'h01);
        cycles(3);
        check("R6 match no irq", {15'h0, irq_a}, 16'h0);
        pins[0] = 1'b0;
        cycles(4);
        check("R6 mismatch irq", {15'h0, irq_a}, 16'h1);
        rd(5'd7, d);
        cycles(1);
        check("R6 persistent re-raise", {15'h0, irq_a}, 16'h1);
        pins[0] = 1'b1;
        cycles(3);
        rd(5'd7, d);
        cycles(3);
        check("R6 cleared on match", {15'h0, irq_a}, 16'h0);

        // R10 mirror
        wr(5'd16, 8'h01);
        wr(5'd10, 8'h01);
        cycles(3);
        pins[8] = ~pins[8];
        cycles(4);
        check("R10 mirror irq_a", {15'h0, irq_a}, 16'h1);
        check("R10 mirror irq_b", {15'h0, irq_b}, 16'h1);
        rd(5'd13, d);
        check("R9 pin read clears B", {14'h0, irq_a, irq_b}, 16'h0);

        // R11 active low
        wr(5'd16, 8'h02);
        cycles(2);
        check("R11 idle high", {14'h0, irq_a, irq_b}, 16'h3);
        pins[0] = 1'b0;
        cycles(4);
        check("R11 port A active", {14'h0, irq_a, irq_b}, 16'h1);
        clear_all();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule